// File: doc/BRIEF.md
# Multidrop Serial Receiver with Station Address Filter

This block is the receive side of a serial port for a shared multidrop line. It runs in one of four framing modes: a clocked shift mode, where the block drives the shift clock and reads eight bits; an 8-bit asynchronous mode; and two 9-bit asynchronous modes. The asynchronous modes oversample each bit 16 times and read it at mid-bit. One 9-bit mode takes its rate from a fixed divider of the system clock. The other 9-bit mode and the 8-bit mode use an externally supplied oversample tick.

On a multidrop bus, a frame whose ninth bit is 1 carries a station address. With multiprocessor filtering enabled, the receiver ignores data frames (ninth bit 0). It accepts an address frame only if the frame hits this station's selective address or its broadcast address. Both addresses come from a station address and a station mask. In the 8-bit mode, the same enable instead rejects frames that have a bad stop bit.

A received frame is presented on a valid/ready output. `rx_valid` rises when an accepted frame completes and stays high until the consumer raises `rx_ready`. While it is high, `rx_data` and `rx_bit9` do not change. Any frame that completes while `rx_valid` is high is dropped. There is no queue, so back-pressure from the consumer costs frames rather than stalling the line.

Top module: `mpu_serial_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_data` and `rx_bit9` are 0 and `shift_clk` is 1.
- R2: Mode 2'b01 receives a start bit, 8 data bits LSB first and a stop bit, with 16 `var_tick` pulses per bit. With `mp_en` = 0, every frame is accepted and `rx_bit9` takes the sampled stop bit.
- R3: Modes 2'b10 and 2'b11 receive a start bit, 8 data bits LSB first, a ninth bit and a stop bit. In mode 2'b10 a bit lasts FIXED_BIT_DIV clocks (32). In mode 2'b11 a bit lasts 16 `var_tick` pulses. With `mp_en` = 0, every frame is accepted and `rx_bit9` takes the ninth bit.
- R4: A low level on `rxd` only begins a frame if the line is still low at the middle of the start bit. Otherwise the receiver returns to idle and reports nothing.
- R5: Selective match: byte b hits when `(b & station_mask) == (station_addr & station_mask)`. Mask zeros are don't-care bits.
- R6: Broadcast match: byte b hits when b has a 1 in every position where `station_addr | station_mask` has a 1. Zeros of that OR are don't-care bits.
- R7: In the 9-bit modes with `mp_en` = 1, a frame is accepted only if its ninth bit is 1 and its byte hits R5 or R6. A rejected frame leaves `rx_valid`, `rx_data` and `rx_bit9` unchanged.
- R8: In mode 2'b01 with `mp_en` = 1, a frame whose sampled stop bit is 0 is rejected and leaves the outputs unchanged. With `mp_en` = 0 the same frame is accepted with `rx_bit9` = 0.
- R9: With `station_addr` = `station_mask` = 0, every address frame is accepted under `mp_en` = 1.
- R10: `rx_valid` holds, with `rx_data` and `rx_bit9` stable, until a cycle with `rx_ready` high, which clears it. A frame that completes while `rx_valid` is high is dropped.
- R11: While `rx_en` is 0 nothing is received and `shift_clk` stays 1. Dropping `rx_en` in mid-frame abandons the frame.
- R12: Mode 2'b00 starts a transfer when `rx_en` = 1 and `rx_valid` = 0. It drives `shift_clk` with a period of SHIFT_DIV clocks (16), low for the first half and high for the second. It samples `rxd` at each rising edge, LSB first, for 8 bits, and raises `rx_valid` after the eighth bit time. `rx_bit9` is left unchanged.
- R13: In the asynchronous modes, `rx_valid` does not rise before the stop bit starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial receive line (idles high) |
| var_tick | input | 1 | 16x oversample enable for modes 2'b01 and 2'b11 |
| mode | input | 2 | Framing mode: 00 shift, 01 8-bit, 10 9-bit fixed rate, 11 9-bit variable rate |
| rx_en | input | 1 | Receive enable |
| mp_en | input | 1 | Multiprocessor filtering enable |
| station_addr | input | DATA_W | Station address |
| station_mask | input | DATA_W | Station address mask |
| rx_ready | input | 1 | Consumer takes the held frame |
| rx_valid | output | 1 | Accepted frame held |
| rx_data | output | DATA_W | Received byte |
| rx_bit9 | output | 1 | Ninth bit, or stop bit in the 8-bit mode |
| shift_clk | output | 1 | Shift clock in mode 2'b00, otherwise high |

## Verification
The bench builds the block with its defaults: DATA_W = 8, OVERSAMPLE = 16, FIXED_BIT_DIV = 32 (a fixed tick every two clocks) and SHIFT_DIV = 16. An 8-bit address space makes it cheap to sweep every byte value. It is swept through the filter at a one-clock `var_tick` rate, and the accept result for each value is computed arithmetically from the selective and broadcast rules. A 64-value span is also swept at the fixed rate, and a slow three-clock tick covers the 8-bit stop-bit gating.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'b00,
    MODE_ASYNC8 = 2'b01,
    MODE_FIX9   = 2'b10,
    MODE_VAR9   = 2'b11
  } rx_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_TAIL,
    ST_SHIFT
  } rx_state_e;

endpackage

// File: rtl/mprx_tick_gen.sv
module mprx_tick_gen
  import mprx_pkg::*;
#(
  parameter int OVERSAMPLE    = 16,
  parameter int FIXED_BIT_DIV = 32,
  parameter int SHIFT_DIV     = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  rx_mode_e mode,
  input  logic     var_tick,
  input  logic     shift_run,
  output logic     os_tick,
  output logic     sh_sample,
  output logic     sh_end,
  output logic     shift_clk
);

  localparam int FIX_DIV    = FIXED_BIT_DIV / OVERSAMPLE;
  localparam int SW         = $clog2(SHIFT_DIV);
  localparam int SHIFT_HALF = SHIFT_DIV / 2;

  logic fix_tick;

  // fixed-rate oversample divider; collapses to a constant enable at ratio 1
  generate
    if (FIX_DIV > 1) begin : g_div
      localparam int FW = $clog2(FIX_DIV);
      logic [FW-1:0] fix_cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)                          fix_cnt <= '0;
        else if (fix_cnt == FW'(FIX_DIV-1))  fix_cnt <= '0;
        else                                 fix_cnt <= fix_cnt + 1'b1;
      end
      assign fix_tick = (fix_cnt == FW'(FIX_DIV-1));
    end else begin : g_nodiv
      assign fix_tick = 1'b1;
    end
  endgenerate

  always_comb begin
    case (mode)
      MODE_FIX9:              os_tick = fix_tick;
      MODE_ASYNC8, MODE_VAR9: os_tick = var_tick;
      default:                os_tick = 1'b0;
    endcase
  end

  // shift-mode phase: low half then high half of each bit
  logic [SW-1:0] phase;
  always_ff @(posedge clk) begin
    if (!rst_n || !shift_run)               phase <= '0;
    else if (phase == SW'(SHIFT_DIV-1))     phase <= '0;
    else                                    phase <= phase + 1'b1;
  end

  assign sh_sample = shift_run && (phase == SW'(SHIFT_HALF-1));
  assign sh_end    = shift_run && (phase == SW'(SHIFT_DIV-1));
  assign shift_clk = !shift_run || (phase >= SW'(SHIFT_HALF));

endmodule

// File: rtl/mprx_framer.sv
module mprx_framer
  import mprx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  rx_mode_e          mode,
  input  logic              rxd_s,
  input  logic              os_tick,
  input  logic              sh_sample,
  input  logic              sh_end,
  input  logic              hold,
  output logic              shift_run,
  output logic              done,
  output logic [DATA_W-1:0] frame_byte,
  output logic              frame_ninth
);

  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int MID  = OVERSAMPLE / 2;
  localparam int TAIL = MID - 1;
  localparam int BW   = $clog2(DATA_W + 1);

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              ninth_r;
  logic              stop_r;
  logic              nine;
  logic [BW-1:0]     last_idx;

  assign nine     = (mode == MODE_FIX9) || (mode == MODE_VAR9);
  assign last_idx = nine ? BW'(DATA_W) : BW'(DATA_W-1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      ninth_r <= 1'b0;
      stop_r  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!rx_en) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_IDLE: begin
            cnt     <= '0;
            bit_idx <= '0;
            if (mode == MODE_SHIFT) begin
              if (!hold) st <= ST_SHIFT;
            end else if (!rxd_s) begin
              st <= ST_START;
            end
          end
          ST_START: if (os_tick) begin
            if (cnt == CW'(MID-1)) begin
              cnt <= '0;
              st  <= rxd_s ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: if (os_tick) begin
            if (cnt == CW'(OVERSAMPLE-1)) begin
              cnt <= '0;
              if (bit_idx < BW'(DATA_W)) shreg   <= {rxd_s, shreg[DATA_W-1:1]};
              else                       ninth_r <= rxd_s;
              if (bit_idx == last_idx) st <= ST_STOP;
              else                     bit_idx <= bit_idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: if (os_tick) begin
            if (cnt == CW'(OVERSAMPLE-1)) begin
              cnt    <= '0;
              stop_r <= rxd_s;
              st     <= ST_TAIL;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_TAIL: if (os_tick) begin
            if (cnt == CW'(TAIL-1)) begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_SHIFT: begin
            if (sh_sample) shreg <= {rxd_s, shreg[DATA_W-1:1]};
            if (sh_end) begin
              if (bit_idx == BW'(DATA_W-1)) begin
                done <= 1'b1;
                st   <= ST_IDLE;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign shift_run   = (st == ST_SHIFT);
  assign frame_byte  = shreg;
  assign frame_ninth = nine ? ninth_r : stop_r;

endmodule

// File: rtl/mprx_addr_match.sv
module mprx_addr_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] mask,
  output logic              given_hit,
  output logic              bcast_hit
);

  logic [DATA_W-1:0] bcast_pat;

  assign bcast_pat = addr | mask;
  assign given_hit = ~|((rx_byte ^ addr) & mask);
  assign bcast_hit = &(rx_byte | ~bcast_pat);

endmodule

// File: rtl/mpu_serial_rx.sv
module mpu_serial_rx
  import mprx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int OVERSAMPLE    = 16,
  parameter int FIXED_BIT_DIV = 32,
  parameter int SHIFT_DIV     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              var_tick,
  input  logic [1:0]        mode,
  input  logic              rx_en,
  input  logic              mp_en,
  input  logic [DATA_W-1:0] station_addr,
  input  logic [DATA_W-1:0] station_mask,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              shift_clk
);

  rx_mode_e          mode_e;
  logic              rxd_m, rxd_s;
  logic              os_tick, sh_sample, sh_end, shift_run;
  logic              frame_done, frame_ninth;
  logic [DATA_W-1:0] frame_byte;
  logic              given_hit, bcast_hit;
  logic              accept;

  assign mode_e = rx_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  mprx_tick_gen #(
    .OVERSAMPLE   (OVERSAMPLE),
    .FIXED_BIT_DIV(FIXED_BIT_DIV),
    .SHIFT_DIV    (SHIFT_DIV)
  ) i_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_e),
    .var_tick (var_tick),
    .shift_run(shift_run),
    .os_tick  (os_tick),
    .sh_sample(sh_sample),
    .sh_end   (sh_end),
    .shift_clk(shift_clk)
  );

  mprx_framer #(
    .DATA_W    (DATA_W),
    .OVERSAMPLE(OVERSAMPLE)
  ) i_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .mode       (mode_e),
    .rxd_s      (rxd_s),
    .os_tick    (os_tick),
    .sh_sample  (sh_sample),
    .sh_end     (sh_end),
    .hold       (rx_valid),
    .shift_run  (shift_run),
    .done       (frame_done),
    .frame_byte (frame_byte),
    .frame_ninth(frame_ninth)
  );

  mprx_addr_match #(.DATA_W(DATA_W)) i_match (
    .rx_byte  (frame_byte),
    .addr     (station_addr),
    .mask     (station_mask),
    .given_hit(given_hit),
    .bcast_hit(bcast_hit)
  );

  always_comb begin
    case (mode_e)
      MODE_SHIFT:  accept = 1'b1;
      MODE_ASYNC8: accept = !mp_en || frame_ninth;
      default:     accept = !mp_en || (frame_ninth && (given_hit || bcast_hit));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_bit9  <= 1'b0;
    end else if (frame_done && accept && rx_en && !rx_valid) begin
      rx_valid <= 1'b1;
      rx_data  <= frame_byte;
      if (mode_e != MODE_SHIFT) rx_bit9 <= frame_ninth;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mpu_serial_rx_chk.sv
module mpu_serial_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              rx_en,
  input logic              mp_en,
  input logic [DATA_W-1:0] station_addr,
  input logic [DATA_W-1:0] station_mask,
  input logic              rx_ready,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit9,
  input logic              shift_clk
);

  logic sel_ok, bc_ok;
  assign sel_ok = (rx_data & station_mask) == (station_addr & station_mask);
  assign bc_ok  = (rx_data & (station_addr | station_mask)) == (station_addr | station_mask);

  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> $stable(rx_data) && $stable(rx_bit9));

  // R7
  ninth_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) && mp_en && mode[1] |-> rx_bit9);

  // R5 R6
  addr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) && mp_en && mode[1] |-> sel_ok || bc_ok);

  // R8
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) && mp_en && mode == 2'b01 |-> rx_bit9);

  // R11
  shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> shift_clk);

  // R11
  no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !rx_valid |=> !rx_valid);

endmodule

bind mpu_serial_rx mpu_serial_rx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .rx_en       (rx_en),
  .mp_en       (mp_en),
  .station_addr(station_addr),
  .station_mask(station_mask),
  .rx_ready    (rx_ready),
  .rx_valid    (rx_valid),
  .rx_data     (rx_data),
  .rx_bit9     (rx_bit9),
  .shift_clk   (shift_clk)
);

// File: tb/test_mpu_serial_rx.sv
module test_mpu_serial_rx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       var_tick = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       rx_en = 1'b0;
  logic       mp_en = 1'b0;
  logic [7:0] station_addr = 8'h00;
  logic [7:0] station_mask = 8'h00;
  logic       rx_ready = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_bit9;
  logic       shift_clk;

  int n_vec = 0;
  int n_bad = 0;
  int vt_div = 1;
  int cyc = 0;
  logic [7:0] last_d = 8'h00;
  logic       last_b9 = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mpu_serial_rx i_mpu_serial_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .var_tick(var_tick), .mode(mode),
    .rx_en(rx_en), .mp_en(mp_en), .station_addr(station_addr),
    .station_mask(station_mask), .rx_ready(rx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .shift_clk(shift_clk)
  );

  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      cyc++;
      c = (c + 1 >= vt_div) ? 0 : c + 1;
      var_tick = (c == 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic take();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_rx(input string tag, input logic [7:0] d, input logic b9);
    chk(rx_valid && rx_data == d && rx_bit9 == b9, tag,
        {6'b0, rx_valid, rx_bit9, rx_data}, {6'b0, 1'b1, b9, d});
    last_d = d;
    last_b9 = b9;
    take();
  endtask

  task automatic expect_none(input string tag);
    chk(!rx_valid && rx_data == last_d && rx_bit9 == last_b9, tag,
        {6'b0, rx_valid, rx_bit9, rx_data}, {6'b0, 1'b0, last_b9, last_d});
  endtask

  task automatic send(input int bclk, input int nd, input logic [8:0] bits,
                      input logic stop_v, input bit early);
    rxd = 1'b0;
    repeat (bclk) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      rxd = bits[i];
      repeat (bclk) @(negedge clk);
    end
    if (early) chk(!rx_valid, "R13 flag before stop", {15'b0, rx_valid}, 16'h0);
    rxd = stop_v;
    repeat (bclk) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bclk) @(negedge clk);
  endtask

  function automatic bit hit(input logic [7:0] b, input logic [7:0] a, input logic [7:0] m);
    logic [7:0] bc;
    bc = a | m;
    return ((b & m) == (a & m)) || ((b & bc) == bc);
  endfunction

  task automatic shift_in(input logic [7:0] d, input string tag);
    int t0;
    rxd = d[0];
    rx_en = 1'b1;
    @(negedge shift_clk);
    t0 = cyc;
    for (int i = 1; i < 8; i++) begin
      @(negedge shift_clk);
      if (i == 1) chk(cyc - t0 == 16, "R12 shift period", 16'(cyc - t0), 16'd16);
      @(negedge clk);
      rxd = d[i];
    end
    repeat (24) @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk);
    expect_rx(tag, d, last_b9);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rx_valid && rx_data == 8'h00 && !rx_bit9 && shift_clk, "R1 reset state",
        {5'b0, shift_clk, rx_valid, rx_bit9, rx_data}, 16'h0400);

    // R11: disabled receiver ignores a frame
    mode = 2'b11; vt_div = 1;
    send(16, 9, 9'h1A5, 1'b1, 1'b0);
    expect_none("R11 rx disabled");

    // R2 / R8 in the 8-bit mode, slow variable tick
    rx_en = 1'b1; mode = 2'b01; vt_div = 3;
    repeat (10) @(negedge clk);
    send(48, 8, 9'h05A, 1'b1, 1'b1);
    expect_rx("R2 8-bit frame", 8'h5A, 1'b1);
    send(48, 8, 9'h081, 1'b0, 1'b0);
    expect_rx("R8 bad stop accepted without mp", 8'h81, 1'b0);
    mp_en = 1'b1;
    send(48, 8, 9'h033, 1'b0, 1'b0);
    expect_none("R8 bad stop rejected with mp");
    send(48, 8, 9'h033, 1'b1, 1'b0);
    expect_rx("R8 good stop with mp", 8'h33, 1'b1);

    // R3: fixed-rate 9-bit mode without filtering
    mp_en = 1'b0; mode = 2'b10;
    send(32, 9, 9'h096, 1'b1, 1'b0);
    expect_rx("R3 ninth bit 0", 8'h96, 1'b0);
    send(32, 9, 9'h169, 1'b1, 1'b0);
    expect_rx("R3 ninth bit 1", 8'h69, 1'b1);

    // R9: reset address values accept any address frame; R7: data frame dropped
    mp_en = 1'b1;
    send(32, 9, 9'h100, 1'b1, 1'b0);
    expect_rx("R9 open filter 00", 8'h00, 1'b1);
    send(32, 9, 9'h17E, 1'b1, 1'b0);
    expect_rx("R9 open filter 7E", 8'h7E, 1'b1);
    send(32, 9, 9'h0C4, 1'b1, 1'b0);
    expect_none("R7 data frame filtered");

    // R5 R6 sweep at the fixed rate
    station_addr = 8'hE0; station_mask = 8'hFA;
    for (int b = 8'hC0; b <= 8'hFF; b++) begin
      send(32, 9, {1'b1, 8'(b)}, 1'b1, 1'b0);
      if (hit(8'(b), station_addr, station_mask)) expect_rx("R5 R6 fixed sweep hit", 8'(b), 1'b1);
      else expect_none("R5 R6 fixed sweep miss");
    end

    // R5 R6 exhaustive sweep at the variable rate
    mode = 2'b11; vt_div = 1;
    station_addr = 8'hC0; station_mask = 8'hF9;
    for (int b = 0; b < 256; b++) begin
      send(16, 9, {1'b1, 8'(b)}, 1'b1, b == 0);
      if (hit(8'(b), station_addr, station_mask)) expect_rx("R5 R6 var sweep hit", 8'(b), 1'b1);
      else expect_none("R5 R6 var sweep miss");
    end
    send(16, 9, 9'h0C2, 1'b1, 1'b0);
    expect_none("R7 matching byte with ninth 0");

    // R10: back-pressure drops the second frame
    mp_en = 1'b0;
    send(16, 9, 9'h011, 1'b1, 1'b0);
    send(16, 9, 9'h122, 1'b1, 1'b0);
    chk(rx_valid && rx_data == 8'h11 && !rx_bit9, "R10 held frame kept",
        {6'b0, rx_valid, rx_bit9, rx_data}, 16'h0211);
    take();
    chk(!rx_valid, "R10 ready clears valid", {15'b0, rx_valid}, 16'h0);
    last_d = 8'h11; last_b9 = 1'b0;

    // R4: short low pulse is not a start bit
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (48) @(negedge clk);
    expect_none("R4 false start rejected");
    send(16, 9, 9'h14D, 1'b1, 1'b0);
    expect_rx("R4 frame after false start", 8'h4D, 1'b1);

    // R11: abort in mid-frame
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      if (i == 3) rx_en = 1'b0;
      rxd = 1'b0;
      repeat (16) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (32) @(negedge clk);
    rx_en = 1'b1;
    repeat (48) @(negedge clk);
    expect_none("R11 aborted frame");
    send(16, 9, 9'h077, 1'b1, 1'b0);
    expect_rx("R11 frame after abort", 8'h77, 1'b0);

    // R12: shift mode, ninth bit left as is
    rx_en = 1'b0;
    @(negedge clk);
    mode = 2'b00;
    @(negedge clk);
    shift_in(8'hA5, "R12 shift A5");
    shift_in(8'h3C, "R12 shift 3C");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule